// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for normal use. Out of reset it keeps the command bus idle while it counts a programmable number of microsecond ticks. It then issues the start-up sequence to the first rank: one precharge-all-banks, eight auto-refresh commands and one mode-register write, each followed by the NOP gap its timing parameter calls for. When configured for two ranks, it then runs the same sequence on the second rank.

When the sequence ends, the block raises its done flag and an enable for the separate periodic-refresh engine. Both stay high until the next reset. The block also clamps the configured CAS latency to a supported value, places it in the mode word, and reports the derived last-data-out-to-precharge delay. The data path, normal read and write traffic, and refresh scheduling belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and the power-up wait, every chip select is high, RAS_n, CAS_n and WE_n are high, and address and bank are zero. The same idle encoding appears on every cycle in which no command is issued. `init_done` and `refresh_en` are low until the sequence ends.
- R2: The first command comes two cycles after the clock edge that samples the WAIT_US-th `us_tick` pulse after reset. Exactly WAIT_US ticks therefore occur before it.
- R3: Precharge-all is encoded RAS_n=0, CAS_n=1, WE_n=0 with address bit 10 set and every other address bit zero. It opens each rank's sequence and is followed by TRP_CYC (3) NOP cycles.
- R4: Eight auto-refresh commands (RAS_n=0, CAS_n=0, WE_n=1) follow. The first comes TRP_CYC+1 cycles after the precharge, and each is TRFC_CYC+1 (8) cycles after the one before it.
- R5: The mode-register write (RAS_n=0, CAS_n=0, WE_n=0, bank 0) comes TRFC_CYC+1 cycles after the last refresh. Its address carries the effective CAS latency in bits [6:4], 0 (sequential) in bit 3, 3'b010 (burst of four) in bits [2:0], and zeros elsewhere.
- R6: The effective CAS latency is 2 for a `cas_cfg` of 0, 1 or 2. It is 3 for a `cas_cfg` of 3 and for any value from 4 to 7.
- R7: `ldo_pre` equals the effective CAS latency minus one.
- R8: With `two_ranks`=1, the second rank's precharge comes TMRD_CYC+1 (3) cycles after the first rank's mode write, and the second rank repeats the first rank's spacing on `sd_cs_n[1]`. With `two_ranks`=0, `sd_cs_n[1]` never goes low. At most one chip select is low in any cycle.
- R9: `init_done` and `refresh_en` rise TMRD_CYC+1 cycles after the last mode write and hold high until reset. No command is issued after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cas_cfg | input | 3 | Requested CAS latency, held stable during the sequence |
| two_ranks | input | 1 | 1 when two chip selects are populated, held stable |
| sd_cs_n | output | 2 | Chip select per rank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank select |
| ldo_pre | output | 3 | Last-data-out-to-precharge delay in cycles |
| refresh_en | output | 1 | Enable for the periodic refresh engine |
| init_done | output | 1 | Initialization complete |

## Verification
Every result has a fixed due cycle measured from the first command. The refresh commands are due at offsets 4, 12, and so on up to 60. The mode write is due at offset 68. The second rank's precharge, or the done flag in a one-rank build, is due 3 cycles after a mode write. The first command is due two edges after the final counted tick. The bench logs every non-idle cycle with its cycle number, sampled at the falling edge. It compares each entry against offsets it derives from its own timing constants, and it checks the tick count seen before the first entry. It reads the CAS-latency results after the run: from the logged mode word, and from `ldo_pre`, which responds at once to `cas_cfg`.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_REF  = 2'd2,
    CMD_MRS  = 2'd3
  } sd_cmd_e;

  typedef enum logic [2:0] {
    PH_WAIT = 3'd0,
    PH_PREA = 3'd1,
    PH_REF  = 3'd2,
    PH_MRS  = 3'd3,
    PH_DONE = 3'd4
  } seq_phase_e;

  // Clamp the requested latency: below 2 becomes 2, unknown becomes 3.
  function automatic logic [2:0] cl_effective(input logic [2:0] req);
    logic [2:0] r;
    case (req)
      3'd0, 3'd1, 3'd2: r = 3'd2;
      3'd3:             r = 3'd3;
      default:          r = 3'd3;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] ldo_delay(input logic [2:0] cl);
    return cl - 3'd1;
  endfunction

  // Mode word: latency in [6:4], sequential type in [3], burst of 4 in [2:0].
  function automatic logic [6:0] mode_bits(input logic [2:0] cl);
    return {cl, 1'b0, 3'b010};
  endfunction

endpackage

// File: rtl/sdram_pwr_wait.sv
module sdram_pwr_wait #(
  parameter int WAIT_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  output logic wait_done
);
  localparam int CW = $clog2(WAIT_US + 1);

  logic [CW-1:0] us_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt    <= '0;
      wait_done <= 1'b0;
    end else if (!wait_done && us_tick) begin
      if (us_cnt == CW'(WAIT_US - 1)) wait_done <= 1'b1;
      else us_cnt <= us_cnt + 1'b1;
    end
  end

  // R1: once the wait has ended it never restarts before reset
  a_r1_wait_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |=> wait_done);

  // R2: the wait can only end on a tick
  a_r2_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_done && !us_tick) |=> !wait_done);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_init_pkg::*;
#(
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 7,
  parameter int TMRD_CYC = 2,
  parameter int NUM_REF  = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wait_done,
  input  logic    two_ranks,
  output sd_cmd_e cmd,
  output logic    rank_sel,
  output logic    seq_done
);
  localparam int MAXGAP = (TRP_CYC > TRFC_CYC) ?
                          ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC) :
                          ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC);
  localparam int GW = $clog2(MAXGAP + 1);
  localparam int RW = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;

  seq_phase_e    phase;
  logic [GW-1:0] gap_cnt;
  logic [RW-1:0] ref_idx;
  logic          gap_end;
  logic          issue;

  always_comb begin
    case (phase)
      PH_PREA: gap_end = (gap_cnt == GW'(TRP_CYC));
      PH_REF:  gap_end = (gap_cnt == GW'(TRFC_CYC));
      PH_MRS:  gap_end = (gap_cnt == GW'(TMRD_CYC));
      default: gap_end = 1'b0;
    endcase
  end

  assign issue = (gap_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_WAIT;
      gap_cnt  <= '0;
      ref_idx  <= '0;
      rank_sel <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT: if (wait_done) phase <= PH_PREA;
        PH_PREA: begin
          if (gap_end) begin
            gap_cnt <= '0;
            ref_idx <= '0;
            phase   <= PH_REF;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        PH_REF: begin
          if (gap_end) begin
            gap_cnt <= '0;
            if (ref_idx == RW'(NUM_REF - 1)) phase <= PH_MRS;
            else ref_idx <= ref_idx + 1'b1;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        PH_MRS: begin
          if (gap_end) begin
            gap_cnt <= '0;
            if (!rank_sel && two_ranks) begin
              rank_sel <= 1'b1;
              phase    <= PH_PREA;
            end else phase <= PH_DONE;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (issue) begin
      case (phase)
        PH_PREA: cmd = CMD_PREA;
        PH_REF:  cmd = CMD_REF;
        PH_MRS:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign seq_done = (phase == PH_DONE);

  // R2: nothing but NOP until the power-up wait has ended
  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_done |-> (cmd == CMD_NOP));

  // R4: each refresh is followed by a NOP cycle
  a_r4_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  // R3: precharge is always followed by a NOP cycle
  a_r3_prea_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PREA) |=> (cmd == CMD_NOP));

  // R9: no command once the sequence has finished
  a_r9_silent_after: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (cmd == CMD_NOP));

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  sd_cmd_e           cmd,
  input  logic              rank_sel,
  input  logic [2:0]        cl,
  output logic [1:0]        cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int A10 = 10;

  always_comb begin
    cs_n  = 2'b11;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    ba    = '0;
    if (cmd != CMD_NOP) cs_n[rank_sel] = 1'b0;
    case (cmd)
      CMD_PREA: begin
        ras_n     = 1'b0;
        we_n      = 1'b0;
        addr[A10] = 1'b1;
      end
      CMD_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      CMD_MRS: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = ADDR_W'(mode_bits(cl));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_US  = 100,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 7,
  parameter int TMRD_CYC = 2,
  parameter int NUM_REF  = 8,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [2:0]        cas_cfg,
  input  logic              two_ranks,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic [2:0]        ldo_pre,
  output logic              refresh_en,
  output logic              init_done
);
  logic       wait_done;
  sd_cmd_e    cmd;
  logic       rank_sel;
  logic       seq_done;
  logic [2:0] cl_eff;

  assign cl_eff     = cl_effective(cas_cfg);
  assign ldo_pre    = ldo_delay(cl_eff);
  assign init_done  = seq_done;
  assign refresh_en = seq_done;

  sdram_pwr_wait #(.WAIT_US(WAIT_US)) u_wait (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wait_done(wait_done)
  );

  sdram_seq_fsm #(
    .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC), .NUM_REF(NUM_REF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_done(wait_done), .two_ranks(two_ranks),
    .cmd(cmd), .rank_sel(rank_sel), .seq_done(seq_done)
  );

  sdram_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .cmd(cmd), .rank_sel(rank_sel), .cl(cl_eff),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr), .ba(sd_ba)
  );

  // R3: precharge-all carries A10 high
  a_r3_a10_prea: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != 2'b11 && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

  // R6: mode write only ever carries a supported latency
  a_r6_mrs_cl: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != 2'b11 && !sd_ras_n && !sd_cas_n && !sd_we_n)
      |-> (sd_addr[6:4] == 3'd2 || sd_addr[6:4] == 3'd3));

  // R8: one rank at a time, second rank only when populated
  a_r8_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sd_cs_n) <= 1);
  a_r8_rank1_dual: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n[1] |-> two_ranks);

  // R9: done and refresh enable hold until reset
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && refresh_en));

  // R1: idle encoding whenever no chip select is low
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n == 2'b11) |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0));

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 10;
  localparam int WAIT_US    = 100;
  localparam int TRP_CYC    = 3;
  localparam int TRFC_CYC   = 7;
  localparam int TMRD_CYC   = 2;
  localparam int NUM_REF    = 8;
  localparam int PER_RANK   = NUM_REF + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic [2:0]  cas_cfg = 3'd3;
  logic        two_ranks = 1'b0;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;
  logic [2:0]  ldo_pre;
  logic        refresh_en, init_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // command log filled by the monitor
  int          cyc;
  int          n_log;
  int          done_cyc;
  int          ticks_before;
  int          idle_bad;
  int          log_cyc[64];
  int          log_kind[64];
  int          log_rank[64];
  logic [12:0] log_addr[64];
  logic [1:0]  log_ba[64];

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cas_cfg(cas_cfg),
    .two_ranks(two_ranks), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .ldo_pre(ldo_pre), .refresh_en(refresh_en), .init_done(init_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tick generator: one pulse every TICK_DIV cycles out of reset
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin div = 0; us_tick = 1'b0; end
      else begin div++; us_tick = (div % TICK_DIV == 0); end
    end
  end

  // monitor: log every non-idle cycle at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cyc = 0; n_log = 0; done_cyc = -1; ticks_before = 0; idle_bad = 0;
      end else begin
        cyc++;
        if (n_log == 0 && us_tick) ticks_before++;
        if (sd_cs_n != 2'b11) begin
          if (n_log < 64) begin
            log_cyc[n_log]  = cyc;
            log_rank[n_log] = (sd_cs_n == 2'b10) ? 0 : (sd_cs_n == 2'b01) ? 1 : 9;
            case ({sd_ras_n, sd_cas_n, sd_we_n})
              3'b010:  log_kind[n_log] = 1;
              3'b001:  log_kind[n_log] = 2;
              3'b000:  log_kind[n_log] = 3;
              default: log_kind[n_log] = 0;
            endcase
            log_addr[n_log] = sd_addr;
            log_ba[n_log]   = sd_ba;
          end
          n_log++;
        end else if (!(sd_ras_n && sd_cas_n && sd_we_n) || sd_addr != 0 || sd_ba != 0) begin
          idle_bad++;
        end
        if (init_done && done_cyc < 0) done_cyc = cyc;
      end
    end
  end

  function automatic int exp_cl(input logic [2:0] c);
    if (c == 3'd3 || c > 3'd3) return 3;
    return 2;
  endfunction

  // offset of the j-th command of a rank from that rank's precharge
  function automatic int exp_off(input int j);
    if (j == 0) return 0;
    if (j <= NUM_REF) return (TRP_CYC + 1) + (j - 1) * (TRFC_CYC + 1);
    return (TRP_CYC + 1) + NUM_REF * (TRFC_CYC + 1);
  endfunction

  function automatic int exp_kind(input int j);
    if (j == 0) return 1;
    if (j <= NUM_REF) return 2;
    return 3;
  endfunction

  task automatic do_reset(input logic [2:0] cfg, input logic dual);
    @(posedge clk); #1;
    rst_n = 1'b0; cas_cfg = cfg; two_ranks = dual;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n && sd_addr == 0,
          "R1 idle pins in reset", int'(sd_cs_n), 3);
    check(!init_done && !refresh_en, "R1 done low in reset", int'(init_done), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic run_and_check(input logic [2:0] cfg, input logic dual);
    int nr;
    int bad;
    int cl;
    int mode_exp;
    int guard;
    do_reset(cfg, dual);
    nr = dual ? 2 : 1;
    cl = exp_cl(cfg);
    mode_exp = (cl << 4) | 2;
    guard = 0;
    while (!init_done && guard < 4000) begin @(negedge clk); guard++; end
    repeat (20) @(negedge clk);

    check(ticks_before == WAIT_US, "R2 ticks before first command", ticks_before, WAIT_US);
    check(idle_bad == 0, "R1 idle encoding between commands", idle_bad, 0);
    check(n_log == nr * PER_RANK, "R8 command count", n_log, nr * PER_RANK);
    if (n_log == nr * PER_RANK) begin
      for (int r = 0; r < nr; r++) begin
        int base = r * PER_RANK;
        bad = 0;
        for (int j = 0; j < PER_RANK; j++)
          if (log_kind[base + j] != exp_kind(j)) bad++;
        check(bad == 0, "R4 order precharge, refreshes, mode write", bad, 0);
        bad = 0;
        for (int j = 1; j <= NUM_REF; j++)
          if (log_cyc[base + j] - log_cyc[base] != exp_off(j)) bad++;
        check(bad == 0, "R4 refresh spacing", bad, 0);
        check(log_cyc[base + PER_RANK - 1] - log_cyc[base] == exp_off(PER_RANK - 1),
              "R5 mode write timing", log_cyc[base + PER_RANK - 1] - log_cyc[base],
              exp_off(PER_RANK - 1));
        check(log_addr[base] == 13'h400, "R3 precharge address A10", int'(log_addr[base]), 'h400);
        check(log_addr[base + PER_RANK - 1] == 13'(mode_exp) && log_ba[base + PER_RANK - 1] == 0,
              "R5 R6 mode word", int'(log_addr[base + PER_RANK - 1]), mode_exp);
        bad = 0;
        for (int j = 0; j < PER_RANK; j++)
          if (log_rank[base + j] != r) bad++;
        check(bad == 0, "R8 rank select", bad, 0);
      end
      if (dual)
        check(log_cyc[PER_RANK] - log_cyc[PER_RANK - 1] == TMRD_CYC + 1,
              "R8 second rank start", log_cyc[PER_RANK] - log_cyc[PER_RANK - 1], TMRD_CYC + 1);
      check(done_cyc == log_cyc[n_log - 1] + TMRD_CYC + 1, "R9 done timing",
            done_cyc, log_cyc[n_log - 1] + TMRD_CYC + 1);
    end
    check(init_done && refresh_en, "R9 done and refresh enable held", int'(init_done), 1);
    check(ldo_pre == 3'(cl - 1), "R7 ldo to precharge", int'(ldo_pre), cl - 1);
  endtask

  task automatic t_single_cl3;  run_and_check(3'd3, 1'b0); endtask
  task automatic t_dual_cl2;    run_and_check(3'd2, 1'b1); endtask
  task automatic t_clamp_low;   run_and_check(3'd0, 1'b0); run_and_check(3'd1, 1'b0); endtask
  task automatic t_unknown_cl;  run_and_check(3'd6, 1'b1); run_and_check(3'd7, 1'b0); endtask

  // R7 R6: latency decode across all codes on the live output
  task automatic t_ldo_sweep;
    for (int c = 0; c < 8; c++) begin
      cas_cfg = 3'(c);
      #1;
      check(ldo_pre == 3'(exp_cl(3'(c)) - 1), "R7 ldo sweep", int'(ldo_pre), exp_cl(3'(c)) - 1);
    end
  endtask

  initial begin
    t_single_cl3();
    t_dual_cl2();
    t_clamp_low();
    t_unknown_cl();
    t_ldo_sweep();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule